// File: doc/BRIEF.md
# Streamed-Array Run Completion Controller

This block runs one pass of a multi-cycle compute core that takes an array one element at a time and returns two results: an array, also one element at a time, and a single scalar. Input elements are pulled from an external input FIFO under a valid/ready exchange with the core. Output elements are pushed into an external output FIFO as they appear. The scalar is captured and shown on the ports only once the run has been declared complete. At that point the block raises a one-cycle completion pulse and reports how many clock edges the run took.

The built-in core is a running sum. Each accepted element is added to an accumulator and also sits in a one-entry holding register until the output FIFO takes it. The scalar strobe fires one cycle after the last element is accepted. If the output FIFO is full at that moment, the last element is written after the scalar strobe. For this reason the block offers two completion policies, chosen by `countMode` and sampled when a start is accepted. With `countMode`=0 the run ends on the scalar strobe alone. With `countMode`=1 the block waits until the scalar has been seen and the number of written elements has reached `OUT_COUNT`.

`OUT_COUNT` must not exceed `ARRAY_LEN`. Only one run is active at a time.

Top module: `stream_run_ctrl`

## Requirements
- R1: While `rstN` is low, and after it is released, `busy`, `donePulse`, `scalarValid`, `inPop` and `outWrite` are 0 and `latency` is 0.
- R2: `inPop` is high only when `busy` is 1, `inEmpty` is 0, the core is ready and fewer than `ARRAY_LEN` elements have been taken in this run. Each run pops exactly `ARRAY_LEN` elements, and a run with no stalls takes one element per cycle.
- R3: Every accepted element is written to the output FIFO exactly once, unchanged and in acceptance order. `outWrite` is never high while `outFull` is 1. A full output FIFO holds the pending element and stops further input pops.
- R4: After completion, `scalarOut` equals the sum of the run's elements modulo 2^`SUM_W` and `scalarValid` is 1. `scalarValid` drops on the edge that accepts a start. `scalarOut` keeps its previous value until the run completes.
- R5: With `countMode`=0, completion happens on the edge after the cycle in which the core's scalar strobe is high. With no stalls this gives a latency of `ARRAY_LEN`+1, plus one for each cycle the input FIFO was empty. This holds even if an output element is still held back at that moment.
- R6: With `countMode`=1, completion happens on the edge after the first cycle in which the scalar has been seen and `OUT_COUNT` elements have been written. With no stalls this gives a latency of `ARRAY_LEN`+2. A last element delayed by one cycle of `outFull` adds one more cycle.
- R7: `donePulse` is high for exactly one cycle per run. It appears in the same cycle that the new `scalarOut`, `scalarValid` and `latency` values appear.
- R8: `latency` equals the number of rising clock edges from the edge that accepted the start to the edge that declared completion.
- R9: A `startPulse` while `busy` is 1 is ignored. It does not alter the latency, the counters or the number of done pulses of the current run.
- R10: The core raises its scalar strobe only after every element of the input array has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a run (ignored while busy) |
| countMode | input | 1 | Completion policy, sampled at start: 0 = scalar strobe, 1 = scalar and element count |
| inEmpty | input | 1 | Input FIFO has no data |
| inData | input | DATA_W | Head element of the input FIFO |
| inPop | output | 1 | Take the head element of the input FIFO |
| outFull | input | 1 | Output FIFO cannot accept a write |
| outWrite | output | 1 | Write `outData` into the output FIFO |
| outData | output | DATA_W | Array output element |
| scalarOut | output | SUM_W | Captured scalar result |
| scalarValid | output | 1 | `scalarOut` belongs to the last finished run |
| donePulse | output | 1 | One-cycle completion strobe |
| latency | output | LAT_W | Edge count of the last finished run |
| busy | output | 1 | A run is active |

## Verification
The core's scalar strobe and the write of the last array element can fall in the same cycle, because both follow the last input acceptance by one edge. The bench provokes a clash between them by raising `outFull` for exactly that one cycle, which pushes the final write one edge past the scalar strobe. It then samples the completion cycle in both modes. With `countMode`=0, the run must end on time with one element still unwritten at the done pulse. With `countMode`=1, the run must end one edge later than in a clean run and with every element already written. Runs without the clash confirm that the two events arriving together give the unstalled latencies.

// File: rtl/srun_pkg.sv
package srun_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clear;   // a start was accepted this cycle
    logic run;     // a run is active
    logic finish;  // completion is declared on the coming edge
  } ctrlStrobe_t;

  // Status from the datapath back to the control
  typedef struct packed {
    logic sumStrobe;   // core scalar valid (one cycle)
    logic outCountMet; // written element count reached the target
  } dpStatus_t;

endpackage

// File: rtl/srun_datapath.sv
module srun_datapath
  import srun_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SUM_W     = 16,
  parameter int ARRAY_LEN = 4,
  parameter int OUT_COUNT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctrl,
  output dpStatus_t         status,
  input  logic              inEmpty,
  input  logic [DATA_W-1:0] inData,
  output logic              inPop,
  input  logic              outFull,
  output logic              outWrite,
  output logic [DATA_W-1:0] outData,
  output logic [SUM_W-1:0]  scalarOut,
  output logic              scalarValid
);

  localparam int IN_W  = $clog2(ARRAY_LEN + 1);
  localparam int OUT_W = $clog2(OUT_COUNT + 1);
  localparam logic [IN_W-1:0]  IN_TOP  = IN_W'(ARRAY_LEN);
  localparam logic [IN_W-1:0]  IN_LAST = IN_W'(ARRAY_LEN - 1);
  localparam logic [OUT_W-1:0] OUT_TOP = OUT_W'(OUT_COUNT);

  logic [IN_W-1:0]   inCnt;
  logic [OUT_W-1:0]  outCnt;
  logic [SUM_W-1:0]  acc;
  logic [SUM_W-1:0]  elemExt;
  logic              holdValid;
  logic [DATA_W-1:0] holdData;
  logic              sumStrobe;
  logic              accepting;
  logic              coreReady;

  // Element widened or trimmed to accumulator width
  generate
    if (SUM_W >= DATA_W) begin : g_widen
      assign elemExt = {{(SUM_W-DATA_W){1'b0}}, inData};
    end else begin : g_trim
      assign elemExt = inData[SUM_W-1:0];
    end
  endgenerate

  // Core handshake: ready while the holding slot is free or draining
  assign accepting = ctrl.run && (inCnt != IN_TOP);
  assign coreReady = !holdValid || !outFull;
  assign inPop     = accepting && coreReady && !inEmpty;
  assign outWrite  = holdValid && !outFull;
  assign outData   = holdData;

  assign status.sumStrobe   = sumStrobe;
  assign status.outCountMet = (outCnt == OUT_TOP);

  // Input side and running sum
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inCnt     <= '0;
      acc       <= '0;
      sumStrobe <= 1'b0;
    end else if (ctrl.clear) begin
      inCnt     <= '0;
      acc       <= '0;
      sumStrobe <= 1'b0;
    end else begin
      sumStrobe <= inPop && (inCnt == IN_LAST);
      if (inPop) begin
        inCnt <= inCnt + 1'b1;
        acc   <= acc + elemExt;
      end
    end
  end

  // One-entry holding slot toward the output FIFO
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdData  <= '0;
    end else if (inPop) begin
      holdValid <= 1'b1;
      holdData  <= inData;
    end else if (outWrite) begin
      holdValid <= 1'b0;
    end
  end

  // Count of written elements, saturating at the target
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCnt <= '0;
    end else if (ctrl.clear) begin
      outCnt <= '0;
    end else if (outWrite && (outCnt != OUT_TOP)) begin
      outCnt <= outCnt + 1'b1;
    end
  end

  // Scalar shown only after completion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scalarOut   <= '0;
      scalarValid <= 1'b0;
    end else if (ctrl.clear) begin
      scalarValid <= 1'b0;
    end else if (ctrl.finish) begin
      scalarOut   <= acc;
      scalarValid <= 1'b1;
    end
  end

endmodule

// File: rtl/srun_control.sv
module srun_control
  import srun_pkg::*;
#(
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             countMode,
  input  dpStatus_t        status,
  output ctrlStrobe_t      ctrl,
  output logic             donePulse,
  output logic [LAT_W-1:0] latency,
  output logic             busy
);

  logic             busyQ;
  logic             modeQ;
  logic             scalarSeen;
  logic [LAT_W-1:0] latCnt;
  logic             startOk;
  logic             finishNow;

  assign startOk   = startPulse && !busyQ;
  assign finishNow = busyQ && (modeQ ? (scalarSeen && status.outCountMet)
                                     : status.sumStrobe);

  assign ctrl.clear  = startOk;
  assign ctrl.run    = busyQ;
  assign ctrl.finish = finishNow;
  assign busy        = busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ      <= 1'b0;
      modeQ      <= 1'b0;
      scalarSeen <= 1'b0;
      latCnt     <= '0;
      latency    <= '0;
      donePulse  <= 1'b0;
    end else begin
      donePulse <= finishNow;
      if (startOk) begin
        busyQ      <= 1'b1;
        modeQ      <= countMode;
        scalarSeen <= 1'b0;
        latCnt     <= '0;
      end else if (busyQ) begin
        latCnt <= latCnt + 1'b1;
        if (status.sumStrobe) scalarSeen <= 1'b1;
        if (finishNow) begin
          busyQ   <= 1'b0;
          latency <= latCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/stream_run_ctrl.sv
module stream_run_ctrl
  import srun_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SUM_W     = 16,
  parameter int ARRAY_LEN = 4,
  parameter int OUT_COUNT = 4,
  parameter int LAT_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              countMode,
  input  logic              inEmpty,
  input  logic [DATA_W-1:0] inData,
  output logic              inPop,
  input  logic              outFull,
  output logic              outWrite,
  output logic [DATA_W-1:0] outData,
  output logic [SUM_W-1:0]  scalarOut,
  output logic              scalarValid,
  output logic              donePulse,
  output logic [LAT_W-1:0]  latency,
  output logic              busy
);

  ctrlStrobe_t ctrl;
  dpStatus_t   status;
  logic        sumStrobe;
  logic        finishStrobe;

  assign sumStrobe    = status.sumStrobe;
  assign finishStrobe = ctrl.finish;

  srun_control #(.LAT_W(LAT_W)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .countMode  (countMode),
    .status     (status),
    .ctrl       (ctrl),
    .donePulse  (donePulse),
    .latency    (latency),
    .busy       (busy)
  );

  srun_datapath #(
    .DATA_W    (DATA_W),
    .SUM_W     (SUM_W),
    .ARRAY_LEN (ARRAY_LEN),
    .OUT_COUNT (OUT_COUNT)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .status      (status),
    .inEmpty     (inEmpty),
    .inData      (inData),
    .inPop       (inPop),
    .outFull     (outFull),
    .outWrite    (outWrite),
    .outData     (outData),
    .scalarOut   (scalarOut),
    .scalarValid (scalarValid)
  );

endmodule

// File: rtl/srun_checker.sv
module srun_checker (
  input logic clk,
  input logic rstN,
  input logic startPulse,
  input logic inEmpty,
  input logic inPop,
  input logic outFull,
  input logic outWrite,
  input logic scalarValid,
  input logic donePulse,
  input logic busy,
  input logic sumStrobe,
  input logic finishStrobe
);

  // R2
  pop_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    inPop |-> (busy && !inEmpty));

  // R3
  write_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    outWrite |-> !outFull);

  // R7
  done_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R4
  done_scalar_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> scalarValid);

  // R4
  start_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !scalarValid);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && !finishStrobe) |=> busy);

  // R10
  scalar_after_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    sumStrobe |-> (busy && !inPop));

endmodule

bind stream_run_ctrl srun_checker u_srun_checker (
  .clk          (clk),
  .rstN         (rstN),
  .startPulse   (startPulse),
  .inEmpty      (inEmpty),
  .inPop        (inPop),
  .outFull      (outFull),
  .outWrite     (outWrite),
  .scalarValid  (scalarValid),
  .donePulse    (donePulse),
  .busy         (busy),
  .sumStrobe    (sumStrobe),
  .finishStrobe (finishStrobe)
);

// File: tb/stream_run_ctrl_tb.sv
module stream_run_ctrl_tb;

  localparam int DATA_W    = 16;
  localparam int SUM_W     = 16;
  localparam int ARRAY_LEN = 4;
  localparam int OUT_COUNT = 4;
  localparam int LAT_W     = 16;
  localparam int NVEC      = 6;
  localparam int WINDOW    = 30;

  // {mode, input-empty cycles, outFull cycle (15 = none), first element}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 4'd0, 4'd15, 16'd10},
    {1'b1, 4'd0, 4'd15, 16'd100},
    {1'b0, 4'd2, 4'd15, 16'd7},
    {1'b1, 4'd3, 4'd15, 16'hFFF0},
    {1'b0, 4'd0, 4'd4,  16'd50},
    {1'b1, 4'd1, 4'd5,  16'd200}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              startPulse;
  logic              countMode;
  logic              inEmpty;
  logic [DATA_W-1:0] inData;
  logic              inPop;
  logic              outFull;
  logic              outWrite;
  logic [DATA_W-1:0] outData;
  logic [SUM_W-1:0]  scalarOut;
  logic              scalarValid;
  logic              donePulse;
  logic [LAT_W-1:0]  latency;
  logic              busy;

  int checks = 0;
  int errors = 0;

  logic [DATA_W-1:0] srcMem [ARRAY_LEN];
  logic [DATA_W-1:0] capMem [ARRAY_LEN];
  int rdPtr;
  int wrCnt;
  logic [SUM_W-1:0] prevSum = '0;

  always #10 clk = ~clk;

  stream_run_ctrl #(
    .DATA_W(DATA_W), .SUM_W(SUM_W), .ARRAY_LEN(ARRAY_LEN),
    .OUT_COUNT(OUT_COUNT), .LAT_W(LAT_W)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .countMode(countMode),
    .inEmpty(inEmpty), .inData(inData), .inPop(inPop), .outFull(outFull),
    .outWrite(outWrite), .outData(outData), .scalarOut(scalarOut),
    .scalarValid(scalarValid), .donePulse(donePulse), .latency(latency),
    .busy(busy)
  );

  assign inData = (rdPtr < ARRAY_LEN) ? srcMem[rdPtr] : '0;

  // Models of the two FIFOs
  always @(posedge clk) begin
    if (inPop) rdPtr <= rdPtr + 1;
    if (outWrite) begin
      if (wrCnt < ARRAY_LEN) capMem[wrCnt] <= outData;
      wrCnt <= wrCnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_run(input bit mode, input int dly, input int fullAt,
                        input logic [DATA_W-1:0] base, input bit startTwice);
    int doneCnt = 0;
    int doneK = -1;
    int wrAtDone = -1;
    logic [SUM_W-1:0] expSum = '0;
    logic [SUM_W-1:0] sawScalar = '0;
    logic [LAT_W-1:0] sawLat = '0;
    bit sawValid = 1'b0;
    bit stalled;
    int expLat;
    @(negedge clk);
    for (int i = 0; i < ARRAY_LEN; i++) begin
      srcMem[i] = base + DATA_W'(i * 3);
      expSum = expSum + SUM_W'(srcMem[i]);
    end
    rdPtr = 0;
    wrCnt = 0;
    countMode = mode;
    startPulse = 1'b1;
    inEmpty = 1'b1;
    outFull = 1'b0;
    @(posedge clk);
    for (int k = 0; k < WINDOW; k++) begin
      @(negedge clk);
      if (k == 0) begin
        check(!scalarValid, "R4 scalarValid low during run", scalarValid, 0);
        check(scalarOut == prevSum, "R4 scalarOut holds previous", scalarOut, prevSum);
      end
      if (donePulse) begin
        doneCnt++;
        if (doneK < 0) begin
          doneK = k;
          wrAtDone = wrCnt;
          sawScalar = scalarOut;
          sawValid = scalarValid;
          sawLat = latency;
        end
      end
      startPulse = startTwice && (k == 1);
      inEmpty = (k < dly);
      outFull = (k == fullAt);
    end
    stalled = (fullAt == dly + ARRAY_LEN);
    expLat = ARRAY_LEN + 1 + dly + (mode ? (stalled ? 2 : 1) : 0);
    check(doneCnt == 1, "R7 one done pulse per run", doneCnt, 1);
    check(sawLat == LAT_W'(expLat), mode ? "R6 latency" : "R5 latency", sawLat, expLat);
    check(doneK == int'(sawLat), "R8 latency equals edges to done", doneK, sawLat);
    check(sawScalar == expSum, "R4 scalar sum", sawScalar, expSum);
    check(sawValid, "R7 scalarValid with done", sawValid, 1);
    check(wrAtDone == ((!mode && stalled) ? ARRAY_LEN - 1 : ARRAY_LEN),
          mode ? "R6 writes at done" : "R5 writes at done", wrAtDone,
          (!mode && stalled) ? ARRAY_LEN - 1 : ARRAY_LEN);
    check(rdPtr == ARRAY_LEN, "R2 pops per run", rdPtr, ARRAY_LEN);
    check(wrCnt == ARRAY_LEN, "R3 writes per run", wrCnt, ARRAY_LEN);
    for (int i = 0; i < ARRAY_LEN; i++)
      check(capMem[i] == srcMem[i], "R3 element order", capMem[i], srcMem[i]);
    check(!busy, "R8 idle after run", busy, 0);
    prevSum = expSum;
  endtask

  // Watchdog
  initial begin
    #(20 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    startPulse = 1'b0;
    countMode = 1'b0;
    inEmpty = 1'b1;
    outFull = 1'b0;
    rdPtr = 0;
    wrCnt = 0;
    for (int i = 0; i < ARRAY_LEN; i++) srcMem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!busy && !donePulse && !scalarValid && !inPop && !outWrite,
          "R1 outputs low in reset", {busy, donePulse, scalarValid, inPop, outWrite}, 0);
    check(latency == '0, "R1 latency zero", latency, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !scalarValid && !inPop, "R1 idle after reset",
          {busy, scalarValid, inPop}, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++)
      do_run(VEC[v][24], int'(VEC[v][23:20]), int'(VEC[v][19:16]), VEC[v][15:0], 1'b0);

    // R9 start during an active run is ignored (both modes)
    do_run(1'b0, 0, 15, 16'd33, 1'b1);
    do_run(1'b1, 0, 15, 16'd44, 1'b1);

    // R10 and R2 with a long input stall: latency grows only by stall length
    do_run(1'b1, 9, 15, 16'd5, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule